// File: doc/BRIEF.md
# USB Interrupt Vector with Clear-on-Read

This block holds the pending interrupt flags of a USB device controller. These are one setup flag and one flag for each input and output endpoint. From them it forms a single prioritized vector value for software. A flag is raised by a one-cycle set pulse from the endpoint logic. Software reads the vector over a simple register bus, and the read strobe has side effects. It clears the one source that the vector reported. When that source is the setup flag, the read also pulses clear requests for the NAK bits of both directions of endpoint 0.

The raw flags are also driven out continuously, so that a direct register read can see them without side effects. Software can therefore handle a newly arrived setup packet before it touches the vector. This matters because input endpoint 0 ranks above the setup flag. The vector is zero when nothing is pending. Otherwise it is an even code suited to a jump table, and it grows as priority falls.

Top module: `usb_int_vec`

## Requirements
- R1: After reset, and whenever no flag is pending, `vec_o` is 0. All flags and both NAK-clear outputs are 0 after reset.
- R2: Codes, from highest to lowest priority, are: input endpoint 0 = 2, setup = 4, output endpoint 0 = 6. For k >= 1, input endpoint k = 4k+4 and output endpoint k = 4k+6. `vec_o` shows the code of the highest-priority pending source, and it is always even.
- R3: When input endpoint 0 and the setup flag are both pending, `vec_o` is 2.
- R4: A clock edge with `rd_vec_i` high clears only the flag that `vec_o` reported in that cycle. All other flags keep their values.
- R5: A read while `vec_o` is 4 clears the setup flag. In the following cycle, both `clr_nak_in0_o` and `clr_nak_out0_o` are high for exactly one cycle.
- R6: The NAK-clear outputs stay low after idle cycles, after reads that report any code other than 4, and after reads that return 0.
- R7: Without a read strobe, pending flags stay set, and the raw flag outputs show them unchanged.
- R8: If a set pulse arrives in the same cycle as a read that clears the same flag, the flag stays set.
- R9: A set pulse in one cycle makes the flag visible on its raw output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_setup_i | input | 1 | Set pulse for the setup flag |
| set_in_i | input | NUM_EP | Set pulses, input endpoint flags |
| set_out_i | input | NUM_EP | Set pulses, output endpoint flags |
| rd_vec_i | input | 1 | Vector read strobe |
| vec_o | output | VEC_W | Current vector code |
| setup_flag_o | output | 1 | Raw setup flag |
| in_flag_o | output | NUM_EP | Raw input endpoint flags |
| out_flag_o | output | NUM_EP | Raw output endpoint flags |
| clr_nak_in0_o | output | 1 | One-cycle clear pulse, input endpoint 0 NAK |
| clr_nak_out0_o | output | 1 | One-cycle clear pulse, output endpoint 0 NAK |

## Verification
Two functions can land on the same flag in the same cycle: a set pulse from the endpoint logic and a clear from a vector read that reports that flag. The bench provokes this by driving `set_setup_i` in the same cycle as a read that returns 4. It then requires that the setup flag is still set, and that the NAK-clear pulses still fire for that read. A second collision is input endpoint 0 and setup pending together. Here the bench requires code 2 first, with no NAK pulse, and code 4 only on the next read.

// File: rtl/usb_int_vec_pkg.sv
package usb_int_vec_pkg;
  localparam int unsigned IN0_CODE   = 2;
  localparam int unsigned SETUP_CODE = 4;
  localparam int unsigned SETUP_IDX  = 1;

  function automatic int unsigned src_count(int unsigned num_ep);
    return 2 * num_ep + 1;
  endfunction

  // max code is 2*src_count
  function automatic int unsigned vec_width(int unsigned num_ep);
    return $clog2(2 * src_count(num_ep) + 1);
  endfunction
endpackage

// File: rtl/usb_int_vec_flags.sv
module usb_int_vec_flags #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  // set has precedence so an arriving event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/usb_int_vec_prio.sv
module usb_int_vec_prio #(
  parameter int unsigned W     = 17,
  parameter int unsigned VEC_W = 6,
  localparam int unsigned IW   = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     req_i,
  output logic             valid_o,
  output logic [IW-1:0]    idx_o,
  output logic [VEC_W-1:0] code_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  assign code_o = valid_o ? ((VEC_W'(idx_o) + VEC_W'(1)) << 1) : '0;
endmodule

// File: rtl/usb_int_vec_nak.sv
module usb_int_vec_nak (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic clr_in0_o,
  output logic clr_out0_o
);
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= fire_i;
  end

  assign clr_in0_o  = pulse_q;
  assign clr_out0_o = pulse_q;
endmodule

// File: rtl/usb_int_vec.sv
module usb_int_vec
  import usb_int_vec_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  localparam int unsigned NSRC  = src_count(NUM_EP),
  localparam int unsigned VEC_W = vec_width(NUM_EP),
  localparam int unsigned IW    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_setup_i,
  input  logic [NUM_EP-1:0] set_in_i,
  input  logic [NUM_EP-1:0] set_out_i,
  input  logic              rd_vec_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              setup_flag_o,
  output logic [NUM_EP-1:0] in_flag_o,
  output logic [NUM_EP-1:0] out_flag_o,
  output logic              clr_nak_in0_o,
  output logic              clr_nak_out0_o
);
  logic [NSRC-1:0] src_set, src_flag, src_clr;
  logic            sel_valid;
  logic [IW-1:0]   sel_idx;

  // priority order: in0, setup, out0, then in_k, out_k for k >= 1
  assign src_set[0]    = set_in_i[0];
  assign src_set[1]    = set_setup_i;
  assign src_set[2]    = set_out_i[0];
  assign in_flag_o[0]  = src_flag[0];
  assign setup_flag_o  = src_flag[1];
  assign out_flag_o[0] = src_flag[2];

  for (genvar k = 1; k < NUM_EP; k++) begin : g_ep
    assign src_set[2*k+1] = set_in_i[k];
    assign src_set[2*k+2] = set_out_i[k];
    assign in_flag_o[k]   = src_flag[2*k+1];
    assign out_flag_o[k]  = src_flag[2*k+2];
  end

  usb_int_vec_flags #(.W(NSRC)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (src_set),
    .clr_i  (src_clr),
    .flag_o (src_flag)
  );

  usb_int_vec_prio #(.W(NSRC), .VEC_W(VEC_W)) i_prio (
    .req_i   (src_flag),
    .valid_o (sel_valid),
    .idx_o   (sel_idx),
    .code_o  (vec_o)
  );

  assign src_clr = (rd_vec_i && sel_valid) ? (NSRC'(1) << sel_idx) : '0;

  usb_int_vec_nak i_nak (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (rd_vec_i && sel_valid && (sel_idx == IW'(SETUP_IDX))),
    .clr_in0_o  (clr_nak_in0_o),
    .clr_out0_o (clr_nak_out0_o)
  );
endmodule

// File: rtl/usb_int_vec_chk.sv
module usb_int_vec_chk #(
  parameter int unsigned NUM_EP = 8,
  parameter int unsigned VEC_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              set_setup_i,
  input logic [NUM_EP-1:0] set_in_i,
  input logic [NUM_EP-1:0] set_out_i,
  input logic              rd_vec_i,
  input logic [VEC_W-1:0]  vec_o,
  input logic              setup_flag_o,
  input logic [NUM_EP-1:0] in_flag_o,
  input logic [NUM_EP-1:0] out_flag_o,
  input logic              clr_nak_in0_o,
  input logic              clr_nak_out0_o
);
  p_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({setup_flag_o, in_flag_o, out_flag_o} == '0) |-> (vec_o == '0));

  p_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o[0] == 1'b0);

  p_in0_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_flag_o[0] |-> (vec_o == VEC_W'(2)));

  p_keep_setup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec_i && vec_o == VEC_W'(2) && setup_flag_o) |=> setup_flag_o);

  p_setup_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec_i && vec_o == VEC_W'(4) && !set_setup_i) |=> !setup_flag_o);

  p_nak_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec_i && vec_o == VEC_W'(4)) |=> (clr_nak_in0_o && clr_nak_out0_o));

  p_no_idle_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_vec_i || vec_o != VEC_W'(4)) |=> (!clr_nak_in0_o && !clr_nak_out0_o));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_vec_i && setup_flag_o) |=> setup_flag_o);

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_setup_i |=> setup_flag_o);

  p_set_vis_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_in_i[0] |=> in_flag_o[0]);
endmodule

bind usb_int_vec usb_int_vec_chk #(.NUM_EP(NUM_EP), .VEC_W(VEC_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .set_setup_i    (set_setup_i),
  .set_in_i       (set_in_i),
  .set_out_i      (set_out_i),
  .rd_vec_i       (rd_vec_i),
  .vec_o          (vec_o),
  .setup_flag_o   (setup_flag_o),
  .in_flag_o      (in_flag_o),
  .out_flag_o     (out_flag_o),
  .clr_nak_in0_o  (clr_nak_in0_o),
  .clr_nak_out0_o (clr_nak_out0_o)
);

// File: tb/test_usb_int_vec.sv
module test_usb_int_vec;
  localparam int unsigned NUM_EP = 8;
  localparam int unsigned VEC_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              set_setup = 1'b0;
  logic [NUM_EP-1:0] set_in = '0;
  logic [NUM_EP-1:0] set_out = '0;
  logic              rd_vec = 1'b0;
  logic [VEC_W-1:0]  vec;
  logic              setup_flag;
  logic [NUM_EP-1:0] in_flag, out_flag;
  logic              clr_in0, clr_out0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usb_int_vec #(.NUM_EP(NUM_EP)) i_usb_int_vec (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .set_setup_i    (set_setup),
    .set_in_i       (set_in),
    .set_out_i      (set_out),
    .rd_vec_i       (rd_vec),
    .vec_o          (vec),
    .setup_flag_o   (setup_flag),
    .in_flag_o      (in_flag),
    .out_flag_o     (out_flag),
    .clr_nak_in0_o  (clr_in0),
    .clr_nak_out0_o (clr_out0)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one-cycle set pulses; flags visible at the following negedge
  task automatic pulse_set(input bit s, input logic [NUM_EP-1:0] i, input logic [NUM_EP-1:0] o);
    @(negedge clk);
    set_setup = s; set_in = i; set_out = o;
    @(negedge clk);
    set_setup = 1'b0; set_in = '0; set_out = '0;
  endtask

  // read with vector checked in the read cycle; pulse checked one cycle later
  task automatic do_read(input string req, input int exp_code, input bit exp_pulse);
    @(negedge clk);
    chk(req, int'(vec), exp_code);
    rd_vec = 1'b1;
    @(negedge clk);
    rd_vec = 1'b0;
    chk(req, int'({clr_in0, clr_out0}), exp_pulse ? 3 : 0);
  endtask

  task automatic t_reset;
    chk("R1 reset vec", int'(vec), 0);
    chk("R1 reset flags", int'({setup_flag, in_flag, out_flag}), 0);
    chk("R1 reset pulse", int'({clr_in0, clr_out0}), 0);
  endtask

  task automatic t_single;
    pulse_set(1'b0, '0, 8'h08);
    chk("R9 out3 visible", int'(out_flag), 8);
    do_read("R2 out3 code", 18, 1'b0);
    chk("R4 out3 cleared", int'(out_flag), 0);
    chk("R1 empty vec", int'(vec), 0);
    pulse_set(1'b0, 8'h04, '0);
    do_read("R2 in2 code", 12, 1'b0);
    chk("R4 in2 cleared", int'(in_flag), 0);
  endtask

  task automatic t_order;
    pulse_set(1'b0, 8'h02, 8'h03);
    do_read("R2 out0 first", 6, 1'b0);
    chk("R4 others kept", int'({in_flag, out_flag}), 16'h0202);
    do_read("R2 in1 code", 8, 1'b0);
    do_read("R2 out1 code", 10, 1'b0);
    chk("R1 all clear", int'(vec), 0);
  endtask

  task automatic t_prio_setup;
    pulse_set(1'b1, 8'h01, '0);
    chk("R3 in0 over setup", int'(vec), 2);
    do_read("R6 in0 read no pulse", 2, 1'b0);
    chk("R4 setup kept", int'(setup_flag), 1);
    do_read("R5 setup read pulses", 4, 1'b1);
    chk("R5 setup cleared", int'(setup_flag), 0);
    @(negedge clk);
    chk("R5 pulse one cycle", int'({clr_in0, clr_out0}), 0);
  endtask

  task automatic t_idle;
    pulse_set(1'b1, '0, '0);
    repeat (3) begin
      @(negedge clk);
      chk("R6 idle no pulse", int'({clr_in0, clr_out0}), 0);
    end
    chk("R7 setup held", int'(setup_flag), 1);
    chk("R7 vec held", int'(vec), 4);
    do_read("R5 clear setup", 4, 1'b1);
  endtask

  task automatic t_collide;
    pulse_set(1'b1, '0, '0);
    @(negedge clk);
    chk("R8 pre vec", int'(vec), 4);
    rd_vec = 1'b1; set_setup = 1'b1;
    @(negedge clk);
    rd_vec = 1'b0; set_setup = 1'b0;
    chk("R8 setup survives", int'(setup_flag), 1);
    chk("R5 collide pulse", int'({clr_in0, clr_out0}), 3);
    do_read("R5 final setup read", 4, 1'b1);
    chk("R8 cleared after", int'(setup_flag), 0);
  endtask

  task automatic t_empty_read;
    do_read("R6 empty read", 0, 1'b0);
    chk("R1 still empty", int'({setup_flag, in_flag, out_flag}), 0);
  endtask

  initial begin
    #1;
    t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_single;
    t_order;
    t_prio_setup;
    t_idle;
    t_collide;
    t_empty_read;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule